// File: doc/BRIEF.md
# NAND Flash Register Bridge

This block is a bus slave that lets a processor drive a raw 8-bit NAND flash device through two word addresses. The first is a control word. The second is a data port. A single write to the control word does three things at once. It sets the chip-enable state, it picks what the next flash cycle means (command byte, address byte, data byte, or arming for reads), and it supplies the byte. The bridge then produces one write-enable pulse with the right latch-enable levels and the byte on the I/O bus. Low and high times are counted in system clocks.

Reads work in two steps. Software first writes the read-arm mode. After that, every read of the data port performs exactly one read-enable cycle on the flash and returns the captured byte. Reading the control word returns the enable and mode currently held, together with a busy flag. The busy flag is taken from the flash ready/busy pin after a two-stage synchronizer.

Every host access is held in a request/acknowledge handshake. The acknowledge comes only after the flash strobe cycle has finished, so accesses issued back to back are never lost.

Top module: `nand_reg_bridge`

## Requirements
- R1: Control word bit 31 is the chip enable: after a control write with bit 31 set, `nandCeN` is 0; with bit 31 clear, it is 1.
- R2: Control bits 30:28 hold the mode. During the write pulse, mode 0 (command) drives `nandCle`=1 and `nandAle`=0. Mode 1 (address) drives `nandAle`=1 and `nandCle`=0. Mode 3 (data write) drives both at 0. In all three, bits 23:16 are placed on `nandIoOut` with `nandIoOe`=1.
- R3: A control write in mode 0, 1 or 3 makes exactly one low pulse on `nandWeN`, lasting LOW_CYC clocks and followed by HIGH_CYC clocks high. `nandCle`, `nandAle` and `nandIoOut` are unchanged across the rising edge of `nandWeN`.
- R4: Bit 15 of a control-word read is 1 while `nandRbN` is low (busy) and 0 while it is high. The pin passes through two flip-flops first.
- R5: A control write of mode 2 (read arm) makes no write pulse. While mode 2 is held, each data-port read makes exactly one `nandReN` low pulse of LOW_CYC clocks. The byte on `nandIoIn` is captured at the end of that pulse and returned in bits 23:16, so consecutive reads return consecutive flash bytes.
- R6: A data-port read while the mode is not 2 makes no read pulse and returns 0.
- R7: A control write with mode 4 to 7 makes no write or read pulse and leaves the I/O bus undriven.
- R8: `busAck` is a single-cycle pulse. It comes LOW_CYC+HIGH_CYC+1 clocks after a request is taken for a strobed access, and 1 clock after for any other access. `busRdata` is valid while `busAck` is high.
- R9: A control-word read returns enable in bit 31, mode in bits 30:28 and busy in bit 15. All other bits are 0.
- R10: After reset, `nandCeN`, `nandWeN` and `nandReN` are 1, `nandCle`, `nandAle` and `nandIoOe` are 0, and the mode reads as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous reset, active low |
| busReq | input | 1 | Access request, held until `busAck` |
| busWr | input | 1 | 1 = write, 0 = read |
| busAddr | input | 1 | 0 = control word, 1 = data port |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data, valid with `busAck` |
| busAck | output | 1 | Access complete |
| nandCeN | output | 1 | Flash chip enable, active low |
| nandCle | output | 1 | Command latch enable |
| nandAle | output | 1 | Address latch enable |
| nandWeN | output | 1 | Write enable, active low |
| nandReN | output | 1 | Read enable, active low |
| nandIoOut | output | 8 | I/O bus output byte |
| nandIoOe | output | 1 | I/O bus output enable |
| nandIoIn | input | 8 | I/O bus input byte |
| nandRbN | input | 1 | Ready/busy pin, low = busy |

## Verification
The hardest case to reach from the ports is a run of data-port reads after an arm write. Here the returned bytes must follow the flash's own read order, and no read may be dropped or doubled. The bench models the flash as a byte source that advances on each rising edge of `nandReN`. It arms the bridge, issues bursts of reads of random length, and compares each byte with the sequence it predicts. Random mode writes, including the unused codes 4 to 7, are interleaved so that disarming and re-arming are covered, along with data-port reads made while disarmed.

// File: rtl/nand_bridge_pkg.sv
package nand_bridge_pkg;
  typedef enum logic [2:0] {
    MODE_CMD  = 3'd0,
    MODE_ADDR = 3'd1,
    MODE_READ = 3'd2,
    MODE_DATA = 3'd3
  } mode_e;

  typedef struct packed {
    logic loadCtrl;
    logic loadSel;
    logic weLow;
    logic reLow;
    logic drive;
    logic capture;
    logic ack;
  } strobe_t;
endpackage

// File: rtl/nand_bridge_ctrl.sv
module nand_bridge_ctrl
  import nand_bridge_pkg::*;
#(
  parameter int LOW_CYC  = 3,
  parameter int HIGH_CYC = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       busReq,
  input  logic       busWr,
  input  logic       busAddr,
  input  logic [2:0] reqMode,
  input  logic       armed,
  output strobe_t    st
);
  localparam int MAXC = (LOW_CYC > HIGH_CYC) ? LOW_CYC : HIGH_CYC;
  localparam int CW   = $clog2(MAXC + 1);
  localparam logic [CW-1:0] LOW_LAST  = CW'(LOW_CYC - 1);
  localparam logic [CW-1:0] HIGH_LAST = CW'(HIGH_CYC - 1);

  typedef enum logic [2:0] {
    S_IDLE, S_WLOW, S_WHIGH, S_RLOW, S_RHIGH, S_DONE
  } state_e;

  state_e state, nextState;
  logic [CW-1:0] cnt;
  logic strobedMode;

  assign strobedMode = (reqMode == MODE_CMD) || (reqMode == MODE_ADDR) ||
                       (reqMode == MODE_DATA);

  always_comb begin
    st        = '0;
    nextState = state;
    unique case (state)
      S_IDLE: if (busReq) begin
        st.loadSel = 1'b1;
        if (busWr && !busAddr) begin
          st.loadCtrl = 1'b1;
          nextState   = strobedMode ? S_WLOW : S_DONE;
        end else if (!busWr && busAddr && armed) begin
          nextState = S_RLOW;
        end else begin
          nextState = S_DONE;
        end
      end
      S_WLOW: begin
        st.weLow = 1'b1;
        st.drive = 1'b1;
        if (cnt == LOW_LAST) nextState = S_WHIGH;
      end
      S_WHIGH: begin
        st.drive = 1'b1;
        if (cnt == HIGH_LAST) nextState = S_DONE;
      end
      S_RLOW: begin
        st.reLow = 1'b1;
        if (cnt == LOW_LAST) begin
          st.capture = 1'b1;
          nextState  = S_RHIGH;
        end
      end
      S_RHIGH: if (cnt == HIGH_LAST) nextState = S_DONE;
      S_DONE: begin
        st.ack    = 1'b1;
        nextState = S_IDLE;
      end
      default: nextState = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= S_IDLE;
      cnt   <= '0;
    end else begin
      state <= nextState;
      cnt   <= (nextState != state) ? '0 : cnt + 1'b1;
    end
  end

  AST_BAD_MODE_NO_STROBE: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_IDLE && busReq && busWr && !busAddr && reqMode[2]) |=> (state == S_DONE)); // R7
  AST_ACK_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    st.ack |=> !st.ack); // R8
  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(st.weLow) |=> (state == S_WLOW || state == S_WHIGH)); // R3
endmodule

// File: rtl/nand_bridge_dp.sv
module nand_bridge_dp
  import nand_bridge_pkg::*;
#(
  parameter int LOW_CYC = 3
) (
  input  logic        clk,
  input  logic        rstN,
  input  strobe_t     st,
  input  logic        busAddr,
  input  logic        ctrlEn,
  input  logic [2:0]  ctrlMode,
  input  logic [7:0]  ctrlByte,
  output logic        armed,
  output logic [31:0] busRdata,
  output logic        busAck,
  output logic        nandCeN,
  output logic        nandCle,
  output logic        nandAle,
  output logic        nandWeN,
  output logic        nandReN,
  output logic [7:0]  nandIoOut,
  output logic        nandIoOe,
  input  logic [7:0]  nandIoIn,
  input  logic        nandRbN
);
  logic       enReg, selData, busy;
  logic [2:0] modeReg;
  logic [7:0] byteReg, rdByte;
  logic [1:0] rbSync;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      enReg   <= 1'b0;
      modeReg <= MODE_CMD;
      byteReg <= '0;
      selData <= 1'b0;
      rdByte  <= '0;
      rbSync  <= 2'b11;
    end else begin
      rbSync <= {rbSync[0], nandRbN};
      if (st.loadCtrl) begin
        enReg   <= ctrlEn;
        modeReg <= ctrlMode;
        byteReg <= ctrlByte;
      end
      if (st.loadSel) begin
        selData <= busAddr;
        rdByte  <= '0;
      end else if (st.capture) begin
        rdByte <= nandIoIn;
      end
    end
  end

  assign busy      = ~rbSync[1];
  assign armed     = (modeReg == MODE_READ);
  assign nandCeN   = ~enReg;
  assign nandCle   = st.drive && (modeReg == MODE_CMD);
  assign nandAle   = st.drive && (modeReg == MODE_ADDR);
  assign nandWeN   = ~st.weLow;
  assign nandReN   = ~st.reLow;
  assign nandIoOe  = st.drive;
  assign nandIoOut = st.drive ? byteReg : 8'h00;
  assign busAck    = st.ack;
  assign busRdata  = !st.ack ? 32'h0 :
                     selData ? {8'h00, rdByte, 16'h0000} :
                               {enReg, modeReg, 12'h000, busy, 15'h0000};

  // checker counters for pulse widths
  logic [7:0] weLowCnt, reLowCnt;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      weLowCnt <= '0;
      reLowCnt <= '0;
    end else begin
      weLowCnt <= nandWeN ? 8'd0 : ((weLowCnt == 8'hFF) ? weLowCnt : weLowCnt + 8'd1);
      reLowCnt <= nandReN ? 8'd0 : ((reLowCnt == 8'hFF) ? reLowCnt : reLowCnt + 8'd1);
    end
  end

  AST_WE_LOW_MIN: assert property (@(posedge clk) disable iff (!rstN)
    $rose(nandWeN) |-> (weLowCnt >= 8'(LOW_CYC))); // R3
  AST_RE_LOW_MIN: assert property (@(posedge clk) disable iff (!rstN)
    $rose(nandReN) |-> (reLowCnt >= 8'(LOW_CYC))); // R5
  AST_WE_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    $rose(nandWeN) |-> ($stable(nandCle) && $stable(nandAle) && $stable(nandIoOut) && nandIoOe)); // R3
  AST_NO_CROSS_STROBE: assert property (@(posedge clk) disable iff (!rstN)
    !nandReN |-> (!nandIoOe && armed)); // R5
endmodule

// File: rtl/nand_reg_bridge.sv
module nand_reg_bridge
  import nand_bridge_pkg::*;
#(
  parameter int LOW_CYC  = 3,
  parameter int HIGH_CYC = 2
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        busReq,
  input  logic        busWr,
  input  logic        busAddr,
  input  logic [31:0] busWdata,
  output logic [31:0] busRdata,
  output logic        busAck,
  output logic        nandCeN,
  output logic        nandCle,
  output logic        nandAle,
  output logic        nandWeN,
  output logic        nandReN,
  output logic [7:0]  nandIoOut,
  output logic        nandIoOe,
  input  logic [7:0]  nandIoIn,
  input  logic        nandRbN
);
  strobe_t st;
  logic    armed;

  nand_bridge_ctrl #(.LOW_CYC(LOW_CYC), .HIGH_CYC(HIGH_CYC)) uCtrl (
    .clk(clk), .rstN(rstN), .busReq(busReq), .busWr(busWr), .busAddr(busAddr),
    .reqMode(busWdata[30:28]), .armed(armed), .st(st)
  );

  nand_bridge_dp #(.LOW_CYC(LOW_CYC)) uDp (
    .clk(clk), .rstN(rstN), .st(st), .busAddr(busAddr),
    .ctrlEn(busWdata[31]), .ctrlMode(busWdata[30:28]), .ctrlByte(busWdata[23:16]),
    .armed(armed), .busRdata(busRdata), .busAck(busAck),
    .nandCeN(nandCeN), .nandCle(nandCle), .nandAle(nandAle),
    .nandWeN(nandWeN), .nandReN(nandReN), .nandIoOut(nandIoOut),
    .nandIoOe(nandIoOe), .nandIoIn(nandIoIn), .nandRbN(nandRbN)
  );
endmodule

// File: tb/tb_nand_reg_bridge.sv
module tb_nand_reg_bridge;
  localparam int LOW_CYC  = 3;
  localparam int HIGH_CYC = 2;

  logic clk = 1'b0, rstN = 1'b0;
  logic busReq = 1'b0, busWr = 1'b0, busAddr = 1'b0;
  logic [31:0] busWdata = '0, busRdata;
  logic busAck, nandCeN, nandCle, nandAle, nandWeN, nandReN, nandIoOe;
  logic [7:0] nandIoOut, nandIoIn;
  logic nandRbN = 1'b1;

  int checks = 0, errors = 0;
  int weRises = 0, reFalls = 0, flashPtr = 0;
  int weRun = 0, weLastRun = 0, reRun = 0, reLastRun = 0;
  logic seenCle, seenAle, seenOe;
  logic [7:0] seenIo;

  always #2 clk = ~clk;

  nand_reg_bridge #(.LOW_CYC(LOW_CYC), .HIGH_CYC(HIGH_CYC)) dut (
    .clk(clk), .rstN(rstN), .busReq(busReq), .busWr(busWr), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(busRdata), .busAck(busAck),
    .nandCeN(nandCeN), .nandCle(nandCle), .nandAle(nandAle), .nandWeN(nandWeN),
    .nandReN(nandReN), .nandIoOut(nandIoOut), .nandIoOe(nandIoOe),
    .nandIoIn(nandIoIn), .nandRbN(nandRbN)
  );

  function automatic logic [7:0] flashByte(int idx);
    return 8'((idx * 37 + 11) ^ (idx >> 2));
  endfunction

  function automatic logic [31:0] expCtrl(logic en, logic [2:0] mode, logic busy);
    return {en, mode, 12'h000, busy, 15'h0000};
  endfunction

  function automatic bit isStrobed(logic [2:0] mode);
    return (mode == 3'd0) || (mode == 3'd1) || (mode == 3'd3);
  endfunction

  assign nandIoIn = flashByte(flashPtr);

  always @(posedge nandWeN) if (rstN) begin
    weRises++; seenCle = nandCle; seenAle = nandAle; seenIo = nandIoOut; seenOe = nandIoOe;
  end
  always @(negedge nandReN) if (rstN) reFalls++;
  always @(posedge nandReN) if (rstN) flashPtr++;

  always @(negedge clk) begin
    if (!nandWeN) weRun++; else if (weRun != 0) begin weLastRun = weRun; weRun = 0; end
    if (!nandReN) reRun++; else if (reRun != 0) begin reLastRun = reRun; reRun = 0; end
  end

  task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic xfer(logic wr, logic addr, logic [31:0] wdata,
                      output logic [31:0] rdata, output int waits);
    @(negedge clk);
    busReq = 1'b1; busWr = wr; busAddr = addr; busWdata = wdata;
    waits = 0;
    do begin
      @(negedge clk);
      waits++;
    end while (!busAck && waits < 100);
    rdata = busRdata;
    busReq = 1'b0;
  endtask

  initial begin
    #300000;
    errors++; checks++;
    $display("FAIL watchdog actual=%h expected=%h", 0, 1);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] rd;
    int waits, w0, r0, expPtr;
    logic curEn;
    logic [2:0] curMode;
    void'($urandom(32'd1234));
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R10: reset state
    chk(nandCeN && nandWeN && nandReN && !nandCle && !nandAle && !nandIoOe,
        "R10", {26'b0, nandCeN, nandWeN, nandReN, nandCle, nandAle, nandIoOe}, 32'h38);
    rstN = 1'b1;
    repeat (2) @(posedge clk);
    xfer(1'b0, 1'b0, 32'h0, rd, waits);
    chk(rd == expCtrl(1'b0, 3'd0, 1'b0), "R10 R9", rd, expCtrl(1'b0, 3'd0, 1'b0));
    chk(waits == 1, "R8 short ack", waits, 1);

    // directed command write
    w0 = weRises;
    xfer(1'b1, 1'b0, 32'h80A5_1234, rd, waits);
    chk(weRises - w0 == 1, "R3 one WE pulse", weRises - w0, 1);
    chk(seenCle && !seenAle && seenOe && seenIo == 8'hA5, "R2 command",
        {seenCle, seenAle, seenOe, seenIo}, {3'b101, 8'hA5});
    chk(weLastRun == LOW_CYC, "R3 WE low width", weLastRun, LOW_CYC);
    chk(waits == LOW_CYC + HIGH_CYC + 1, "R8 strobed ack", waits, LOW_CYC + HIGH_CYC + 1);
    chk(!nandCeN, "R1 CE asserted", nandCeN, 0);
    chk(!nandIoOe, "R2 bus released", nandIoOe, 0);

    // R6: data read while not armed
    r0 = reFalls;
    xfer(1'b0, 1'b1, 32'h0, rd, waits);
    chk(rd == 32'h0 && reFalls == r0, "R6 unarmed read", rd, 32'h0);

    // random mode writes
    for (int i = 0; i < 60; i++) begin
      curEn = 1'($urandom);
      curMode = 3'($urandom);
      if (curMode == 3'd2) curMode = 3'd3;
      w0 = weRises; r0 = reFalls;
      xfer(1'b1, 1'b0, {curEn, curMode, 4'h0, 8'($urandom), 16'($urandom)}, rd, waits);
      if (isStrobed(curMode)) begin
        chk(weRises - w0 == 1, "R3 random WE", weRises - w0, 1);
        chk(seenCle == (curMode == 3'd0) && seenAle == (curMode == 3'd1) && seenOe,
            "R2 random latch levels", {seenCle, seenAle, seenOe},
            {curMode == 3'd0, curMode == 3'd1, 1'b1});
      end else begin
        chk(weRises == w0 && reFalls == r0 && !nandIoOe, "R7 unused mode no strobe",
            weRises - w0, 0);
        chk(waits == 1, "R8 unused mode ack", waits, 1);
      end
      chk(nandCeN == !curEn, "R1 CE follows bit31", nandCeN, !curEn);
      xfer(1'b0, 1'b0, 32'h0, rd, waits);
      chk(rd == expCtrl(curEn, curMode, 1'b0), "R9 readback", rd, expCtrl(curEn, curMode, 1'b0));
      if (i % 7 == 0) begin
        r0 = reFalls;
        xfer(1'b0, 1'b1, 32'h0, rd, waits);
        chk(rd == 32'h0 && reFalls == r0, "R6 random unarmed read", rd, 32'h0);
      end
    end

    // armed read bursts
    for (int b = 0; b < 6; b++) begin
      w0 = weRises;
      xfer(1'b1, 1'b0, 32'h2000_0000 | (b[0] ? 32'h8000_0000 : 32'h0) | 32'h00FF_0000, rd, waits);
      chk(weRises == w0, "R5 arm makes no WE", weRises - w0, 0);
      expPtr = flashPtr;
      for (int k = 0; k < 1 + int'($urandom % 5); k++) begin
        r0 = reFalls;
        xfer(1'b0, 1'b1, 32'h0, rd, waits);
        chk(rd == {8'h00, flashByte(expPtr), 16'h0}, "R5 read byte", rd,
            {8'h00, flashByte(expPtr), 16'h0});
        chk(reFalls - r0 == 1 && reLastRun == LOW_CYC, "R5 one RE pulse", reFalls - r0, 1);
        chk(waits == LOW_CYC + HIGH_CYC + 1, "R8 read ack", waits, LOW_CYC + HIGH_CYC + 1);
        expPtr++;
      end
      xfer(1'b1, 1'b0, 32'h3000_0000, rd, waits);
    end

    // R4: busy synchronizer
    @(negedge clk); nandRbN = 1'b0;
    repeat (3) @(negedge clk);
    xfer(1'b0, 1'b0, 32'h0, rd, waits);
    chk(rd[15] == 1'b1, "R4 busy set", rd[15], 1);
    @(negedge clk); nandRbN = 1'b1;
    repeat (3) @(negedge clk);
    xfer(1'b0, 1'b0, 32'h0, rd, waits);
    chk(rd[15] == 1'b0, "R4 busy clear", rd[15], 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule